// File: doc/BRIEF.md
# Paged Segmentation Address Translator

This block maps a logical address made of a segment number and a segment offset onto a physical address. Translation takes two table lookups. The first is a segment-table read, which returns a valid flag, read/write/execute permissions, a segment length and the base of that segment's page table. The second is a page-table read at that base plus the page index taken from the offset. The frame number found in the page-table entry is joined with the in-page offset to form the physical address.

Software fills both tables through two independent configuration write ports. Lookups use a request/response pair with valid/ready handshakes. The block holds one request at a time and has a fixed latency. Each response carries either a physical address or a fault code, and a fault response always carries a zero address.

The control is a three-state machine:
- `ST_IDLE` accepts a request and starts the segment-table read.
- `ST_SEGCHK` evaluates the segment entry and starts the page-table read.
- `ST_RESP` presents the result.

Its transitions are:
- ACCEPT: `ST_IDLE` to `ST_SEGCHK`, taken when `req_valid` and `req_ready` are both high.
- LOOKUP: `ST_SEGCHK` to `ST_RESP`, taken unconditionally.
- RETIRE: `ST_RESP` to `ST_IDLE`, taken when `rsp_ready` is high.
- WAIT: stay in `ST_IDLE` when there is no request, or stay in `ST_RESP` when `rsp_ready` is low.

Top module: `pst_translator`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0. Every segment entry is invalid and every page entry is not present, so any request answers with fault code 1.
- R2: A request accepted in cycle c produces `rsp_valid` in cycle c+2 and not in cycle c+1. `req_ready` stays 0 from cycle c+1 until the response is taken.
- R3: While `rsp_valid` is 1 and `rsp_ready` is 0, the response holds unchanged. In the cycle after the response is taken, `rsp_valid` is 0 and `req_ready` is 1.
- R4: A segment whose valid bit is clear, or whose number is at or above `SEG_DEPTH`, gives fault code 1 (segment invalid).
- R5: An offset greater than or equal to the segment length gives fault code 2 (length). An offset of length-1 is legal, and a length of 0 rejects every offset.
- R6: The access codes are 0 = read, 1 = write, 2 = execute and 3 = reserved. The permission bits are bit0 = read, bit1 = write, bit2 = execute. An access whose bit is clear, and every access with code 3, gives fault code 3 (protection).
- R7: When the selected page entry has its present bit clear, the response carries fault code 4 (page not present).
- R8: When several faults apply, the reported code is chosen in this order: 1, then 2, then 3, then 4.
- R9: On success the fault code is 0 and the physical address is frame*1024 + offset[9:0]. The page-table index is (base + offset[15:10]) mod `PT_DEPTH`. For example, segment 15 with length 5096, offset 3921 and a page at frame 12 gives 13137.
- R10: Every response with a nonzero fault code carries a physical address of 0.
- R11: A configuration write replaces the whole entry at its index. Later requests see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_seg_we | input | 1 | Write a segment entry |
| cfg_seg_idx | input | $clog2(SEG_DEPTH) | Segment entry index |
| cfg_seg_valid | input | 1 | Segment valid flag |
| cfg_seg_perm | input | 3 | Permissions {exec, write, read} |
| cfg_seg_len | input | OFF_W+1 | Segment length in bytes |
| cfg_seg_base | input | $clog2(PT_DEPTH) | Page-table base index |
| cfg_pte_we | input | 1 | Write a page entry |
| cfg_pte_idx | input | $clog2(PT_DEPTH) | Page entry index |
| cfg_pte_present | input | 1 | Page present flag |
| cfg_pte_frame | input | FRAME_W | Frame number |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Segment offset |
| req_acc | input | 2 | Access type |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when high |
| rsp_paddr | output | FRAME_W+PG_OFF_W | Physical address |
| rsp_fault | output | 3 | Fault code, 0 when none |

## Verification
The bench builds the block with its default parameters: 32 segment entries, 256 page entries, 18-bit segment numbers, 16-bit offsets and 12-bit frames. With only 32 entries implemented, segment numbers just above the table and far above it are both reachable, which exercises R4. An 8-bit base added to a 6-bit page index lets page-table indexes wrap past 255. A full-width 17-bit length lets the largest offset, 65535, be checked as legal.

// File: rtl/pst_pkg.sv
package pst_pkg;
    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_SEG  = 3'd1,
        FLT_LEN  = 3'd2,
        FLT_PROT = 3'd3,
        FLT_PAGE = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } access_e;
endpackage

// File: rtl/pst_seg_table.sv
module pst_seg_table #(
    parameter int SEG_W     = 18,
    parameter int SEG_DEPTH = 32,
    parameter int LEN_W     = 17,
    parameter int BASE_W    = 8,
    localparam int IDX_W    = $clog2(SEG_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [2:0]        wr_perm,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [BASE_W-1:0] wr_base,
    input  logic              rd_en,
    input  logic [SEG_W-1:0]  rd_seg,
    output logic              q_valid,
    output logic [2:0]        q_perm,
    output logic [LEN_W-1:0]  q_len,
    output logic [BASE_W-1:0] q_base
);
    typedef struct packed {
        logic              valid;
        logic [2:0]        perm;
        logic [LEN_W-1:0]  len;
        logic [BASE_W-1:0] base;
    } seg_ent_t;

    seg_ent_t mem [SEG_DEPTH];
    seg_ent_t q;
    logic     in_range;

    // numbers past the implemented depth read back as an invalid entry
    assign in_range = ({1'b0, rd_seg} < (SEG_W+1)'(SEG_DEPTH));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SEG_DEPTH; i++) mem[i] <= '0;
            q <= '0;
        end else begin
            if (wr_en) mem[wr_idx] <= '{valid: wr_valid, perm: wr_perm, len: wr_len, base: wr_base};
            if (rd_en) q <= in_range ? mem[rd_seg[IDX_W-1:0]] : '0;
        end
    end

    assign q_valid = q.valid;
    assign q_perm  = q.perm;
    assign q_len   = q.len;
    assign q_base  = q.base;

    AST_OOR_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !in_range) |=> !q_valid); // R4
endmodule

// File: rtl/pst_page_table.sv
module pst_page_table #(
    parameter int DEPTH   = 256,
    parameter int FRAME_W = 12,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_present,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic               rd_en,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               q_present,
    output logic [FRAME_W-1:0] q_frame
);
    typedef struct packed {
        logic               present;
        logic [FRAME_W-1:0] frame;
    } pte_t;

    pte_t mem [DEPTH];
    pte_t q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            q <= '0;
        end else begin
            if (wr_en) mem[wr_idx] <= '{present: wr_present, frame: wr_frame};
            if (rd_en) q <= mem[rd_idx];
        end
    end

    assign q_present = q.present;
    assign q_frame   = q.frame;
endmodule

// File: rtl/pst_fault_check.sv
module pst_fault_check
    import pst_pkg::*;
#(
    parameter int OFF_W = 16,
    localparam int LEN_W = OFF_W + 1
) (
    input  logic             seg_valid,
    input  logic [2:0]       seg_perm,
    input  logic [LEN_W-1:0] seg_len,
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       acc,
    output logic [2:0]       fault
);
    logic allowed;

    always_comb begin
        unique case (access_e'(acc))
            ACC_READ:  allowed = seg_perm[0];
            ACC_WRITE: allowed = seg_perm[1];
            ACC_EXEC:  allowed = seg_perm[2];
            default:   allowed = 1'b0;
        endcase
    end

    // ordered: segment, length, protection (page checked one stage later)
    always_comb begin
        if (!seg_valid)                   fault = FLT_SEG;
        else if ({1'b0, off} >= seg_len)  fault = FLT_LEN;
        else if (!allowed)                fault = FLT_PROT;
        else                              fault = FLT_NONE;
    end
endmodule

// File: rtl/pst_translator.sv
module pst_translator
    import pst_pkg::*;
#(
    parameter int SEG_W     = 18,
    parameter int OFF_W     = 16,
    parameter int PG_OFF_W  = 10,
    parameter int SEG_DEPTH = 32,
    parameter int PT_DEPTH  = 256,
    parameter int FRAME_W   = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_seg_we,
    input  logic [$clog2(SEG_DEPTH)-1:0]  cfg_seg_idx,
    input  logic                          cfg_seg_valid,
    input  logic [2:0]                    cfg_seg_perm,
    input  logic [OFF_W:0]                cfg_seg_len,
    input  logic [$clog2(PT_DEPTH)-1:0]   cfg_seg_base,
    input  logic                          cfg_pte_we,
    input  logic [$clog2(PT_DEPTH)-1:0]   cfg_pte_idx,
    input  logic                          cfg_pte_present,
    input  logic [FRAME_W-1:0]            cfg_pte_frame,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [SEG_W-1:0]              req_seg,
    input  logic [OFF_W-1:0]              req_off,
    input  logic [1:0]                    req_acc,
    output logic                          rsp_valid,
    input  logic                          rsp_ready,
    output logic [FRAME_W+PG_OFF_W-1:0]   rsp_paddr,
    output logic [2:0]                    rsp_fault
);
    localparam int LEN_W    = OFF_W + 1;
    localparam int PT_AW    = $clog2(PT_DEPTH);
    localparam int PG_IDX_W = OFF_W - PG_OFF_W;
    localparam int PADDR_W  = FRAME_W + PG_OFF_W;

    typedef enum logic [1:0] {ST_IDLE, ST_SEGCHK, ST_RESP} st_e;

    st_e               state, state_nx;
    logic              accept;
    logic [OFF_W-1:0]  off_q;
    logic [1:0]        acc_q;
    logic [2:0]        flt_q;
    logic [2:0]        seg_fault;
    logic              seg_valid;
    logic [2:0]        seg_perm;
    logic [LEN_W-1:0]  seg_len;
    logic [PT_AW-1:0]  seg_base;
    logic [PT_AW-1:0]  pt_idx;
    logic              pte_present;
    logic [FRAME_W-1:0] pte_frame;

    assign accept = req_valid && req_ready;
    assign pt_idx = seg_base + PT_AW'(off_q[OFF_W-1 -: PG_IDX_W]);

    pst_seg_table #(
        .SEG_W(SEG_W), .SEG_DEPTH(SEG_DEPTH), .LEN_W(LEN_W), .BASE_W(PT_AW)
    ) u_seg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_seg_we), .wr_idx(cfg_seg_idx), .wr_valid(cfg_seg_valid),
        .wr_perm(cfg_seg_perm), .wr_len(cfg_seg_len), .wr_base(cfg_seg_base),
        .rd_en(accept), .rd_seg(req_seg),
        .q_valid(seg_valid), .q_perm(seg_perm), .q_len(seg_len), .q_base(seg_base)
    );

    pst_fault_check #(.OFF_W(OFF_W)) u_chk (
        .seg_valid(seg_valid), .seg_perm(seg_perm), .seg_len(seg_len),
        .off(off_q), .acc(acc_q), .fault(seg_fault)
    );

    pst_page_table #(.DEPTH(PT_DEPTH), .FRAME_W(FRAME_W)) u_pt (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_pte_we), .wr_idx(cfg_pte_idx),
        .wr_present(cfg_pte_present), .wr_frame(cfg_pte_frame),
        .rd_en(state == ST_SEGCHK), .rd_idx(pt_idx),
        .q_present(pte_present), .q_frame(pte_frame)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = ST_SEGCHK;
            ST_SEGCHK: state_nx = ST_RESP;
            ST_RESP:   if (rsp_ready) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // request capture and first-stage verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= '0;
            acc_q <= '0;
            flt_q <= FLT_NONE;
        end else begin
            if (accept) begin
                off_q <= req_off;
                acc_q <= req_acc;
            end
            if (state == ST_SEGCHK) flt_q <= seg_fault;
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_fault = FLT_NONE;
        rsp_paddr = '0;
        unique case (state)
            ST_IDLE:   req_ready = 1'b1;
            ST_SEGCHK: ;
            ST_RESP: begin
                rsp_valid = 1'b1;
                if (flt_q != FLT_NONE) rsp_fault = flt_q;
                else if (!pte_present) rsp_fault = FLT_PAGE;
                else rsp_paddr = {pte_frame, off_q[PG_OFF_W-1:0]};
            end
            default: ;
        endcase
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !rsp_valid ##1 rsp_valid); // R2
    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R2
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault))); // R3
    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 3'd0) |-> (rsp_paddr == '0)); // R10
    AST_FAULT_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault <= 3'd4)); // R8
endmodule

// File: tb/sim_pst_translator.sv
module sim_pst_translator;
    localparam int CLK_PERIOD = 10;
    localparam int SEGS = 32;
    localparam int PTES = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_seg_we = 0, cfg_seg_valid = 0;
    logic [4:0]  cfg_seg_idx = '0;
    logic [2:0]  cfg_seg_perm = '0;
    logic [16:0] cfg_seg_len = '0;
    logic [7:0]  cfg_seg_base = '0;
    logic        cfg_pte_we = 0, cfg_pte_present = 0;
    logic [7:0]  cfg_pte_idx = '0;
    logic [11:0] cfg_pte_frame = '0;
    logic        req_valid = 0, rsp_ready = 0;
    logic        req_ready, rsp_valid;
    logic [17:0] req_seg = '0;
    logic [15:0] req_off = '0;
    logic [1:0]  req_acc = '0;
    logic [21:0] rsp_paddr;
    logic [2:0]  rsp_fault;

    int checks = 0, errors = 0;
    bit done = 0;

    int sh_v[SEGS], sh_p[SEGS], sh_l[SEGS], sh_b[SEGS];
    int pt_p[PTES], pt_f[PTES];

    always #(CLK_PERIOD/2) clk = ~clk;

    pst_translator u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_seg_we(cfg_seg_we), .cfg_seg_idx(cfg_seg_idx), .cfg_seg_valid(cfg_seg_valid),
        .cfg_seg_perm(cfg_seg_perm), .cfg_seg_len(cfg_seg_len), .cfg_seg_base(cfg_seg_base),
        .cfg_pte_we(cfg_pte_we), .cfg_pte_idx(cfg_pte_idx),
        .cfg_pte_present(cfg_pte_present), .cfg_pte_frame(cfg_pte_frame),
        .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
        .req_off(req_off), .req_acc(req_acc),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_fault(int seg, int off, int acc);
        int idx;
        if (seg >= SEGS || sh_v[seg] == 0) return 1;
        if (off >= sh_l[seg]) return 2;
        if (acc == 3 || ((sh_p[seg] >> acc) & 1) == 0) return 3;
        idx = (sh_b[seg] + (off >> 10)) % PTES;
        if (pt_p[idx] == 0) return 4;
        return 0;
    endfunction

    function automatic longint exp_paddr(int seg, int off, int acc);
        if (exp_fault(seg, off, acc) != 0) return 0;
        return longint'(pt_f[(sh_b[seg] + (off >> 10)) % PTES]) * 1024 + (off % 1024);
    endfunction

    task automatic put_seg(int idx, int v, int p, int len, int base);
        @(negedge clk);
        cfg_seg_we = 1; cfg_seg_idx = 5'(idx); cfg_seg_valid = v[0];
        cfg_seg_perm = 3'(p); cfg_seg_len = 17'(len); cfg_seg_base = 8'(base);
        sh_v[idx] = v; sh_p[idx] = p; sh_l[idx] = len; sh_b[idx] = base;
        @(negedge clk);
        cfg_seg_we = 0;
    endtask

    task automatic put_pte(int idx, int p, int frame);
        @(negedge clk);
        cfg_pte_we = 1; cfg_pte_idx = 8'(idx); cfg_pte_present = p[0];
        cfg_pte_frame = 12'(frame);
        pt_p[idx] = p; pt_f[idx] = frame;
        @(negedge clk);
        cfg_pte_we = 0;
    endtask

    // one translation with protocol and result checks; tag names the requirement under test
    task automatic xlate(int seg, int off, int acc, int stall, string tag);
        int ef; longint ea;
        logic [21:0] pa; logic [2:0] pf;
        ef = exp_fault(seg, off, acc);
        ea = exp_paddr(seg, off, acc);
        @(negedge clk);
        check(req_ready == 1'b1, "R3", "ready before request", req_ready, 1);
        req_valid = 1; req_seg = 18'(seg); req_off = 16'(off); req_acc = 2'(acc);
        @(negedge clk);
        req_valid = 0;
        check(rsp_valid == 1'b0, "R2", "rsp_valid one cycle after accept", rsp_valid, 0);
        check(req_ready == 1'b0, "R2", "ready while busy", req_ready, 0);
        @(negedge clk);
        check(rsp_valid == 1'b1, "R2", "rsp_valid two cycles after accept", rsp_valid, 1);
        pa = rsp_paddr; pf = rsp_fault;
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            check(rsp_valid && rsp_paddr == pa && rsp_fault == pf, "R3", "held during stall",
                  rsp_paddr, pa);
        end
        check(rsp_fault == 3'(ef), tag, "fault code", rsp_fault, ef);
        check(rsp_paddr == 22'(ea), tag, "physical address", rsp_paddr, ea);
        if (ef != 0)
            check(rsp_paddr == '0, "R10", "zero address on fault", rsp_paddr, 0);
        rsp_ready = 1;
        @(negedge clk);
        rsp_ready = 0;
        check(!rsp_valid && req_ready, "R3", "idle after retire", {rsp_valid, req_ready}, 1);
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0017));
        for (int i = 0; i < SEGS; i++) begin sh_v[i] = 0; sh_p[i] = 0; sh_l[i] = 0; sh_b[i] = 0; end
        for (int i = 0; i < PTES; i++) begin pt_p[i] = 0; pt_f[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", "reset handshake", {req_ready, rsp_valid}, 2);
        xlate(0, 0, 0, 0, "R1");
        xlate(31, 100, 2, 1, "R1");

        // R9 worked example: segment 15, offset 3921 -> page 3, frame 12
        put_seg(15, 1, 3'b001, 5096, 40);
        put_pte(43, 1, 12);
        put_pte(44, 1, 7);
        xlate(15, 3921, 0, 2, "R9");
        check(exp_paddr(15, 3921, 0) == 13137, "R9", "example address model", exp_paddr(15, 3921, 0), 13137);
        // R5 length edge
        xlate(15, 5095, 0, 0, "R5");
        xlate(15, 5096, 0, 0, "R5");
        put_seg(3, 1, 3'b111, 0, 0);
        xlate(3, 0, 0, 0, "R5");
        put_seg(4, 1, 3'b001, 65536, 0);
        put_pte(63, 1, 4095);
        xlate(4, 65535, 0, 0, "R5");
        // R4 beyond depth and invalid
        xlate(32, 0, 0, 0, "R4");
        xlate(18'h3ffff, 0, 0, 0, "R4");
        put_seg(5, 0, 3'b111, 1000, 0);
        xlate(5, 10, 0, 0, "R4");
        // R6 protection
        put_seg(6, 1, 3'b011, 4096, 100);
        put_pte(100, 1, 9);
        xlate(6, 5, 2, 0, "R6");
        xlate(6, 5, 1, 0, "R6");
        put_seg(7, 1, 3'b111, 4096, 100);
        xlate(7, 5, 3, 0, "R6");
        xlate(7, 5, 2, 0, "R6");
        // R7 page absent
        put_seg(8, 1, 3'b001, 4096, 120);
        xlate(8, 2000, 0, 0, "R7");
        // R8 priority
        xlate(5, 60000, 3, 0, "R8");
        put_seg(9, 1, 3'b000, 100, 120);
        xlate(9, 200, 1, 0, "R8");
        xlate(9, 50, 1, 0, "R8");
        put_seg(10, 1, 3'b001, 4096, 120);
        xlate(10, 50, 0, 0, "R8");
        // R9 base + page wrap
        put_seg(11, 1, 3'b001, 65536, 250);
        put_pte(4, 1, 321);
        xlate(11, 10 * 1024 + 77, 0, 0, "R9");
        // R11 rewrite
        put_pte(4, 1, 555);
        xlate(11, 10 * 1024 + 77, 0, 0, "R11");
        put_seg(11, 0, 3'b001, 65536, 250);
        xlate(11, 10 * 1024 + 77, 0, 0, "R11");

        // random phase
        for (int round = 0; round < 6; round++) begin
            for (int s = 0; s < SEGS; s++)
                put_seg(s, ($urandom % 8) != 0, $urandom % 8, $urandom % 65537, $urandom % PTES);
            for (int k = 0; k < 64; k++)
                put_pte($urandom % PTES, ($urandom % 6) != 0, $urandom % 4096);
            for (int t = 0; t < 60; t++) begin
                int sg, of;
                sg = ($urandom % 10 == 0) ? 32 + ($urandom % 1000) : $urandom % SEGS;
                of = $urandom % 65536;
                if (sg < SEGS && sh_l[sg] > 0 && ($urandom % 2)) of = $urandom % sh_l[sg];
                xlate(sg, of, $urandom % 4, $urandom % 3, "R9");
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule